// File: doc/BRIEF.md
# Bit-Inverting Branch Processor

This block is a minimal processor core. It knows one operation: read a single bit from data memory, write that bit back inverted, and pick the next program address from what was read. Each 32-bit instruction word carries the two operands the operation needs, a branch target and a data address. The core therefore never computes a data address. Data memory can only be reached at locations that are written into the program.

The core drives a program address to an external program ROM and takes back the instruction word the same cycle, because the ROM read is combinational. The data address goes straight from the low half of that word to an external 1-bit-wide RAM. A write strobe selects between reading and writing. Each instruction takes two clock cycles. In the read cycle the strobe is low and the addressed bit is sampled. In the write cycle the strobe is high and the inverted bit is driven out at the same address. The next program address is then taken from the bit that was read. Reset is asynchronous and active-low, and its release is synchronised to the clock.

Top module: `invert_branch_cpu`

## Requirements
- R1: While `rst_n` is low, `rom_addr` is 0 and `ram_we` is 0. After `rst_n` rises, the core stays in this state for two more rising clock edges before its first read cycle.
- R2: Bits [31:16] of `rom_data` are the branch target and bits [15:0] are the data address. `ram_addr` equals `rom_data[15:0]` in both cycles of an instruction.
- R3: After reset the core alternates strictly between a read cycle (`ram_we` = 0) and a write cycle (`ram_we` = 1), starting with a read cycle.
- R4: In the write cycle `ram_wdata` is the inverse of the `ram_rdata` value sampled at the end of the read cycle. After that cycle the RAM bit holds the inverted value.
- R5: If the bit read was 0, the next instruction's `rom_addr` is the branch target of the current word.
- R6: If the bit read was 1, the next `rom_addr` is the current one plus 1, wrapping from 0xFFFF to 0x0000.
- R7: Pulling `rst_n` low during a write cycle drops `ram_we` at once and returns `rom_addr` to 0. No RAM bit changes because of that interrupted instruction.
- R8: `rom_addr` and `ram_addr` do not change between the read cycle and the write cycle of one instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| rom_addr | output | 16 | Program counter, used as the ROM address |
| rom_data | input | 32 | Instruction word: branch target [31:16], data address [15:0] |
| ram_addr | output | 16 | RAM bit address, taken from the instruction word |
| ram_rdata | input | 1 | RAM read bit |
| ram_wdata | output | 1 | Inverted bit to be written |
| ram_we | output | 1 | Write strobe: 0 read, 1 write |

## Verification
The bench builds the core with its default 16-bit program counter and 16-bit data address. With these widths the full program space is in reach: a directed branch to 0xFFFF followed by a 1-bit there exercises the wrap to 0x0000. The randomly filled part of the program keeps its branch targets and data addresses inside small windows, so the same RAM bits are flipped many times. A reset pulled in the middle of a write cycle checks that the interrupted instruction leaves memory untouched.

// File: rtl/invbr_pkg.sv
package invbr_pkg;
  typedef enum logic {
    PH_READ  = 1'b0,
    PH_WRITE = 1'b1
  } phase_e;
endpackage

// File: rtl/invbr_rst_sync.sv
module invbr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] shift_q;
  logic [STAGES-1:0] shift_d;

  always_comb shift_d = {shift_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shift_q <= '0;
    else        shift_q <= shift_d;
  end

  assign rst_sync_n = shift_q[STAGES-1];
endmodule

// File: rtl/invbr_phase_seq.sv
module invbr_phase_seq
  import invbr_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  output phase_e phase,
  output logic   instr_done
);
  phase_e phase_q, phase_d;

  always_comb begin
    case (phase_q)
      PH_READ:  phase_d = PH_WRITE;
      default:  phase_d = PH_READ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_READ;
    else        phase_q <= phase_d;
  end

  assign phase      = phase_q;
  assign instr_done = (phase_q == PH_WRITE);
endmodule

// File: rtl/invbr_bit_latch.sv
module invbr_bit_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic capture,
  input  logic din,
  output logic bit_q
);
  logic bit_d;

  always_comb bit_d = capture ? din : bit_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bit_q <= 1'b0;
    else        bit_q <= bit_d;
  end
endmodule

// File: rtl/invbr_pc_unit.sv
module invbr_pc_unit #(
  parameter int PC_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            advance,
  input  logic            bit_read,
  input  logic [PC_W-1:0] branch_tgt,
  output logic [PC_W-1:0] pc
);
  logic [PC_W-1:0] pc_q, pc_d;

  always_comb begin
    if (bit_read) pc_d = pc_q + PC_W'(1);
    else          pc_d = branch_tgt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pc_q <= '0;
    else if (advance) pc_q <= pc_d;
  end

  assign pc = pc_q;
endmodule

// File: rtl/invert_branch_cpu.sv
module invert_branch_cpu
  import invbr_pkg::*;
#(
  parameter int PC_W = 16,
  parameter int DA_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  output logic [PC_W-1:0]      rom_addr,
  input  logic [PC_W+DA_W-1:0] rom_data,
  output logic [DA_W-1:0]      ram_addr,
  input  logic                 ram_rdata,
  output logic                 ram_wdata,
  output logic                 ram_we
);
  localparam int IW = PC_W + DA_W;

  logic            rst_sync_n;
  phase_e          phase;
  logic            instr_done;
  logic            bit_q;
  logic [PC_W-1:0] branch_tgt;

  // field split of the instruction word
  assign branch_tgt = rom_data[IW-1 -: PC_W];
  assign ram_addr   = rom_data[DA_W-1:0];

  invbr_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  invbr_phase_seq u_phase (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .phase      (phase),
    .instr_done (instr_done)
  );

  invbr_bit_latch u_bit (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .capture (phase == PH_READ),
    .din     (ram_rdata),
    .bit_q   (bit_q)
  );

  invbr_pc_unit #(.PC_W(PC_W)) u_pc (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .advance    (instr_done),
    .bit_read   (bit_q),
    .branch_tgt (branch_tgt),
    .pc         (rom_addr)
  );

  assign ram_we    = (phase == PH_WRITE);
  assign ram_wdata = ~bit_q;
endmodule

// File: rtl/invbr_checker.sv
module invbr_checker #(
  parameter int PC_W = 16,
  parameter int DA_W = 16
) (
  input logic                 clk,
  input logic                 rst_sync_n,
  input logic [PC_W-1:0]      rom_addr,
  input logic [PC_W+DA_W-1:0] rom_data,
  input logic [DA_W-1:0]      ram_addr,
  input logic                 ram_rdata,
  input logic                 ram_wdata,
  input logic                 ram_we
);
  localparam int IW = PC_W + DA_W;

  // R1: held in reset state until synchronised release
  p_reset_state_r1: assert property (@(posedge clk)
    !rst_sync_n |-> (rom_addr == '0) && !ram_we);

  // R3: strict alternation of read and write cycles
  p_write_then_read_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ram_we |=> !ram_we);
  p_read_then_write_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !ram_we |=> ram_we);

  // R4: written bit is the inverse of the bit read one cycle earlier
  p_wdata_inverted_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ram_we |-> (ram_wdata == !$past(ram_rdata)));

  // R8: addresses held across the two cycles of an instruction
  p_addr_hold_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ram_we |-> ($stable(rom_addr) && $stable(ram_addr)));

  // R5: bit 0 takes the branch
  p_branch_taken_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ($fell(ram_we) && !$past(ram_rdata, 2)) |-> (rom_addr == $past(rom_data[IW-1 -: PC_W])));

  // R6: bit 1 steps by one with wrap
  p_step_wrap_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ($fell(ram_we) && $past(ram_rdata, 2)) |-> (rom_addr == PC_W'($past(rom_addr) + PC_W'(1))));
endmodule

bind invert_branch_cpu invbr_checker #(.PC_W(PC_W), .DA_W(DA_W)) u_invbr_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .rom_addr   (rom_addr),
  .rom_data   (rom_data),
  .ram_addr   (ram_addr),
  .ram_rdata  (ram_rdata),
  .ram_wdata  (ram_wdata),
  .ram_we     (ram_we)
);

// File: tb/invert_branch_cpu_bench.sv
`timescale 1ns/1ps
module invert_branch_cpu_bench;
  logic        clk;
  logic        rst_n;
  logic [15:0] rom_addr;
  logic [31:0] rom_data;
  logic [15:0] ram_addr;
  logic        ram_rdata;
  logic        ram_wdata;
  logic        ram_we;

  logic [65535:0] ram;
  logic [65535:0] mram;
  logic [31:0]    rom_tbl [0:255];

  int n_cmp = 0;
  int n_mis = 0;
  bit finished = 0;

  logic [15:0] exp_pc;
  logic [15:0] last_a;
  bit          have_last;

  invert_branch_cpu u_invert_branch_cpu (
    .clk       (clk),
    .rst_n     (rst_n),
    .rom_addr  (rom_addr),
    .rom_data  (rom_data),
    .ram_addr  (ram_addr),
    .ram_rdata (ram_rdata),
    .ram_wdata (ram_wdata),
    .ram_we    (ram_we)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [31:0] rom_word(input logic [15:0] a);
    case (a)
      16'h0000: rom_word = {16'h0005, 16'h0010};
      16'h0005: rom_word = {16'hFFFF, 16'h0020};
      16'hFFFF: rom_word = {16'h1234, 16'h0021};
      default:  rom_word = (a < 16'd256) ? rom_tbl[a[7:0]]
                                         : {16'h0000, 10'h0, a[5:0]};
    endcase
  endfunction

  always_comb rom_data = rom_word(rom_addr);
  assign ram_rdata = ram[ram_addr];
  always @(posedge clk) if (ram_we) ram[ram_addr] <= ram_wdata;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] expv);
    n_cmp++;
    if (!ok) begin
      n_mis++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, expv, $time);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
      $finish;
    end
  endtask

  // reset sequence; rst_n is raised on a falling edge
  task automatic do_reset();
    rst_n = 1'b0;
    #1;
    chk(rom_addr == 16'h0, "R1 pc in reset", {16'h0, rom_addr}, 0);
    chk(ram_we == 1'b0, "R1 we in reset", {31'h0, ram_we}, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk(ram_we == 1'b0 && rom_addr == 16'h0, "R1 held after release",
        {15'h0, ram_we, rom_addr}, 0);
    @(posedge clk);
    exp_pc    = 16'h0;
    have_last = 0;
  endtask

  // one instruction; abort_in_write pulls reset during the write cycle
  task automatic run_instr(input bit abort_in_write);
    logic [31:0] w;
    logic [15:0] a;
    logic        b;
    @(negedge clk);
    if (have_last)
      chk(ram[last_a] == mram[last_a], "R4 ram bit after write",
          {31'h0, ram[last_a]}, {31'h0, mram[last_a]});
    w = rom_word(exp_pc);
    a = w[15:0];
    b = mram[a];
    chk(rom_addr == exp_pc, "R5/R6 program counter", {16'h0, rom_addr}, {16'h0, exp_pc});
    chk(ram_we == 1'b0, "R3 read cycle", {31'h0, ram_we}, 0);
    chk(ram_addr == a, "R2 data address field", {16'h0, ram_addr}, {16'h0, a});
    @(negedge clk);
    chk(ram_we == 1'b1, "R3 write cycle", {31'h0, ram_we}, 1);
    chk(rom_addr == exp_pc && ram_addr == a, "R8 addresses held",
        {rom_addr, ram_addr}, {exp_pc, a});
    chk(ram_wdata == ~b, "R4 inverted write data", {31'h0, ram_wdata}, {31'h0, ~b});
    if (abort_in_write) begin
      rst_n = 1'b0;
      #1;
      chk(ram_we == 1'b0, "R7 strobe drops on reset", {31'h0, ram_we}, 0);
      chk(rom_addr == 16'h0, "R7 pc cleared", {16'h0, rom_addr}, 0);
      @(posedge clk);
      #1;
      chk(ram == mram, "R7 memory untouched", {31'h0, ram == mram}, 1);
      do_reset();
    end else begin
      mram[a] = ~b;
      if (b) exp_pc = exp_pc + 16'd1;
      else   exp_pc = w[31:16];
      last_a    = a;
      have_last = 1;
    end
  endtask

  initial begin
    #2_000_000;
    n_cmp++;
    n_mis++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < 256; i++) begin
      logic [31:0] r;
      r = $urandom;
      rom_tbl[i] = {8'h00, r[23:16], 10'h0, r[5:0]};
    end
    ram = '0;
    for (int i = 0; i < 64; i++) ram[i] = 1'($urandom);
    ram[16'h0010] = 1'b0;
    ram[16'h0020] = 1'b0;
    ram[16'h0021] = 1'b1;
    mram = ram;
    @(negedge clk);
    do_reset();
    // directed path: 0 -> 5 (R5), 5 -> FFFF (R5), FFFF -> 0 wrap (R6), 0 -> 1 (R6)
    for (int i = 0; i < 4; i++) run_instr(0);
    chk(exp_pc == 16'h0001, "R6 wrap path reached", {16'h0, exp_pc}, 1);
    for (int i = 0; i < 300; i++) run_instr(0);
    run_instr(1);
    for (int i = 0; i < 300; i++) run_instr(0);
    @(negedge clk);
    chk(ram == mram, "R4 final memory image", {31'h0, ram == mram}, 1);
    report();
  end
endmodule